// File: doc/BRIEF.md
# Error Locator Root Search over GF(2^11)

The block finds the roots of an error locator polynomial by evaluating it at every element of the binary extension field GF(2^M) (default M = 11, reduction polynomial x^11 + x^2 + 1). A one-cycle `start` latches the polynomial degree. The block then steps through the field elements in a fixed order. It does not store the elements: each one is derived from the previous one by a single multiply-by-x. Each element is evaluated with Horner's rule on one combinational GF multiplier. The block reads one coefficient per clock from an external coefficient store through `coef_addr`/`coef_data`, beginning with the highest coefficient.

For each field element the block produces one error bit. The bit is 1 exactly when the polynomial evaluates to zero at that element. The bits leave on a valid/ready stream together with their element index. A transfer takes place on a rising edge where `err_valid` and `err_ready` are both high. While `err_ready` is low, the current bit and index stay frozen, and evaluation of the next element may finish but waits before replacing them. When the last bit has been accepted, `done` pulses for one cycle and `root_count` holds the number of ones sent. Permuting the resulting vector is left to the consumer.

Top module: `root_search`

## Requirements
- R1: After reset `busy`, `err_valid` and `done` are low and `root_count` is zero.
- R2: Field products are reduced modulo x^M + POLY (default POLY = 0x005, that is x^11 + x^2 + 1). `err_bit` is 1 exactly when sigma(e) = sum of coef[k]·e^k over k = 0..degree equals zero.
- R3: Elements are visited in index order 0 to N-1 with N = 2^M. Index 0 is the zero element, and index i ≥ 1 is x^(i-1). Every index is sent exactly once, in increasing order, on `err_index`.
- R4: Evaluation uses Horner's rule, acc = acc·e + coef[j], with j running from the latched degree down to 0. `coef_addr` carries j, and `coef_data` must return coef[j] combinationally in the same cycle.
- R5: While `err_ready` stays high, each element takes degree+1 cycles. `done` is high after the N·(degree+1)+1-th rising edge following the edge that sampled `start`.
- R6: While `err_valid` is high and `err_ready` is low, `err_valid`, `err_bit` and `err_index` hold their values on the next cycle.
- R7: `done` is a single-cycle pulse that follows the transfer of index N-1. While `done` is high, `busy` and `err_valid` are low.
- R8: From `done` until the next accepted `start`, `root_count` equals the number of bits sent as 1 and does not change.
- R9: A `start` pulse, or a change of `degree`, while `busy` is high has no effect on the running search.
- R10: With degree 0 the polynomial is the constant coef[0]. A zero constant marks all N bits, and a nonzero constant marks none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when idle |
| degree | input | DW = clog2(T_MAX+1) | Polynomial degree, at most T_MAX, latched at start |
| coef_addr | output | DW | Index of the coefficient being requested |
| coef_data | input | M | Coefficient at `coef_addr`, same cycle |
| busy | output | 1 | Search in progress |
| err_valid | output | 1 | Error bit available |
| err_ready | input | 1 | Consumer accepts the error bit |
| err_bit | output | 1 | 1 when the element is a root |
| err_index | output | M | Element index of `err_bit` |
| done | output | 1 | One-cycle pulse after the last transfer |
| root_count | output | M+1 | Number of roots found in the last search |

## Verification
With `err_ready` held high, the bit for element i becomes valid after rising edge (i+1)·(degree+1) counted from the start edge. `done` follows one edge after the last transfer, at edge N·(degree+1)+1. The bench drives and samples only on falling edges, counts rising edges from the edge that took `start`, and compares that count against the formula. Under random back-pressure the bench checks only what each accepted transfer carries, its index and bit, because timing then depends on the stall pattern. `root_count` is read after `done`.

// File: rtl/root_search_pkg.sv
package root_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_FLUSH = 2'd2
  } rs_state_t;

endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int          M    = 11,
  parameter logic [M-1:0] POLY = 11'h005
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);

  // MSB-first shift-and-add; each shift folds the overflow bit back via POLY.
  always_comb begin
    p = '0;
    for (int i = M - 1; i >= 0; i--) begin
      p = {p[M-2:0], 1'b0} ^ (p[M-1] ? POLY : '0);
      if (b[i]) p = p ^ a;
    end
  end

endmodule

// File: rtl/field_walker.sv
module field_walker #(
  parameter int          M    = 11,
  parameter logic [M-1:0] POLY = 11'h005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  output logic [M-1:0] value,
  output logic [M-1:0] index
);

  logic [M-1:0] times_x;

  assign times_x = {value[M-2:0], 1'b0} ^ (value[M-1] ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      index <= '0;
    end else if (clear) begin
      value <= '0;
      index <= '0;
    end else if (advance) begin
      value <= (index == '0) ? {{(M-1){1'b0}}, 1'b1} : times_x;
      index <= index + 1'b1;
    end
  end

endmodule

// File: rtl/err_out_stage.sv
module err_out_stage #(
  parameter int M = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         bit_in,
  input  logic [M-1:0] idx_in,
  input  logic         ready,
  output logic         valid,
  output logic         bit_out,
  output logic [M-1:0] idx_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      bit_out <= 1'b0;
      idx_out <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      bit_out <= bit_in;
      idx_out <= idx_in;
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/root_search.sv
module root_search
  import root_search_pkg::*;
#(
  parameter int           M     = 11,
  parameter logic [M-1:0] POLY  = 11'h005,
  parameter int           T_MAX = 50,
  localparam int          N     = 1 << M,
  localparam int          DW    = $clog2(T_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] degree,
  output logic [DW-1:0] coef_addr,
  input  logic [M-1:0]  coef_data,
  output logic          busy,
  output logic          err_valid,
  input  logic          err_ready,
  output logic          err_bit,
  output logic [M-1:0]  err_index,
  output logic          done,
  output logic [M:0]    root_count
);

  localparam logic [M-1:0] LAST_IDX = M'(N - 1);

  rs_state_t     state_q;
  logic [DW-1:0] deg_q;
  logic [DW-1:0] step_q;
  logic [M-1:0]  acc_q;
  logic [M-1:0]  prod;
  logic [M-1:0]  acc_nxt;
  logic [M-1:0]  elem_val;
  logic [M-1:0]  elem_idx;
  logic [M:0]    cnt_q;
  logic          done_q;
  logic          final_step;
  logic          slot_free;
  logic          load_out;
  logic          walk_clear;
  logic          walk_adv;
  logic          is_root;

  gf_mul #(.M(M), .POLY(POLY)) u_mul (
    .a (acc_q),
    .b (elem_val),
    .p (prod)
  );

  field_walker #(.M(M), .POLY(POLY)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (walk_clear),
    .advance (walk_adv),
    .value   (elem_val),
    .index   (elem_idx)
  );

  assign acc_nxt    = prod ^ coef_data;
  assign is_root    = (acc_nxt == '0);
  assign final_step = (step_q == '0);
  assign slot_free  = !err_valid || err_ready;
  assign load_out   = (state_q == ST_EVAL) && final_step && slot_free;
  assign walk_clear = (state_q == ST_IDLE) && start;
  assign walk_adv   = load_out && (elem_idx != LAST_IDX);

  err_out_stage #(.M(M)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_out),
    .bit_in  (is_root),
    .idx_in  (elem_idx),
    .ready   (err_ready),
    .valid   (err_valid),
    .bit_out (err_bit),
    .idx_out (err_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      deg_q   <= '0;
      step_q  <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            deg_q   <= degree;
            step_q  <= degree;
            acc_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!final_step) begin
            acc_q  <= acc_nxt;
            step_q <= step_q - 1'b1;
          end else if (slot_free) begin
            cnt_q  <= cnt_q + (M+1)'(is_root);
            acc_q  <= '0;
            step_q <= deg_q;
            if (elem_idx == LAST_IDX) state_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (err_valid && err_ready) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign coef_addr  = step_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign root_count = cnt_q;

endmodule

// File: rtl/root_search_chk.sv
module root_search_chk #(
  parameter int M  = 11,
  parameter int DW = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         err_valid,
  input logic         err_ready,
  input logic         err_bit,
  input logic [M-1:0] err_index,
  input logic         done,
  input logic [M:0]   root_count
);

  logic         seen_q;
  logic [M-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (done) begin
      seen_q <= 1'b0;
    end else if (err_valid && err_ready) begin
      seen_q <= 1'b1;
      prev_q <= err_index;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !err_ready |=> err_valid && $stable(err_bit) && $stable(err_index));

  assert_first_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !seen_q |-> err_index == '0);

  assert_next_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && seen_q |-> err_index == prev_q + 1'b1);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !err_valid);

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(root_count));

endmodule

bind root_search root_search_chk #(.M(M), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .err_valid  (err_valid),
  .err_ready  (err_ready),
  .err_bit    (err_bit),
  .err_index  (err_index),
  .done       (done),
  .root_count (root_count)
);

// File: tb/root_search_tb.sv
module root_search_tb;

  localparam int          M     = 5;
  localparam logic [4:0]  POLY  = 5'h05;
  localparam int          T_MAX = 6;
  localparam int          N     = 1 << M;
  localparam int          DW    = $clog2(T_MAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] degree = '0;
  logic [DW-1:0] coef_addr;
  logic [M-1:0]  coef_data;
  logic          busy, err_valid, err_bit, done;
  logic          err_ready = 1'b1;
  logic [M-1:0]  err_index;
  logic [M:0]    root_count;

  logic [M-1:0]  mem [T_MAX+1];
  int            n_chk = 0;
  int            n_bad = 0;
  logic [15:0]   lfsr = 16'hACE1;

  always #10 clk = ~clk;

  assign coef_data = (int'(coef_addr) <= T_MAX) ? mem[coef_addr] : '0;

  root_search #(.M(M), .POLY(POLY), .T_MAX(T_MAX)) u_dut (
    .clk, .rst_n, .start, .degree, .coef_addr, .coef_data, .busy,
    .err_valid, .err_ready, .err_bit, .err_index, .done, .root_count
  );

  function automatic logic [M-1:0] xt(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    logic [M-1:0] s = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r = r ^ s;
      s = xt(s);
    end
    return r;
  endfunction

  function automatic logic [M-1:0] elem(input int i);
    logic [M-1:0] v = 1;
    if (i == 0) return '0;
    for (int k = 1; k < i; k++) v = xt(v);
    return v;
  endfunction

  function automatic logic [M-1:0] sigma(input int d, input logic [M-1:0] e);
    logic [M-1:0] acc = '0;
    for (int j = d; j >= 0; j--) acc = gmul(acc, e) ^ mem[j];
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fill mem with the product of (x + r) over the given roots, times scale.
  task automatic build(input int nr, input logic [M-1:0] roots [T_MAX], input logic [M-1:0] scale);
    for (int k = 0; k <= T_MAX; k++) mem[k] = '0;
    mem[0] = 1;
    for (int r = 0; r < nr; r++) begin
      for (int k = T_MAX; k >= 1; k--) mem[k] = mem[k-1] ^ gmul(roots[r], mem[k]);
      mem[0] = gmul(roots[r], mem[0]);
    end
    for (int k = 0; k <= T_MAX; k++) mem[k] = gmul(mem[k], scale);
  endtask

  task automatic run(input string tag, input int d, input bit bp, input bit poke);
    int cyc = 0;
    int got = 0;
    int exp_cnt = 0;
    degree = DW'(d);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    forever begin
      err_ready = bp ? lfsr[0] | lfsr[3] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (poke) begin
        start  = (cyc == 5);
        degree = (cyc == 5) ? DW'(1) : DW'(d);
      end
      if (err_valid && err_ready) begin
        logic eb = (sigma(d, elem(got)) == '0);
        chk(err_index == M'(got), {tag, " R3 index"}, int'(err_index), got);
        chk(err_bit == eb, {tag, " R2 R4 bit"}, int'(err_bit), int'(eb));
        exp_cnt += int'(eb);
        got++;
      end
      if (done) break;
      if (cyc > 40000) begin
        chk(1'b0, {tag, " watchdog"}, cyc, 0);
        break;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    err_ready = 1'b1;
    chk(got == N, {tag, " R3 transfers"}, got, N);
    chk(!busy && !err_valid, {tag, " R7 idle at done"}, int'(busy), 0);
    if (!bp) chk(cyc == N * (d + 1) + 1, {tag, " R5 latency"}, cyc, N * (d + 1) + 1);
    @(negedge clk);
    chk(!done, {tag, " R7 pulse"}, int'(done), 0);
    chk(int'(root_count) == exp_cnt, {tag, " R8 count"}, int'(root_count), exp_cnt);
    repeat (3) @(negedge clk);
    chk(int'(root_count) == exp_cnt, {tag, " R8 count held"}, int'(root_count), exp_cnt);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [M-1:0] rt [T_MAX];
    for (int k = 0; k <= T_MAX; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !err_valid && !done && root_count == '0, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // roots 0, 1, x^3
    rt[0] = '0; rt[1] = elem(1); rt[2] = elem(4);
    build(3, rt, 1);
    run("c1", 3, 1'b0, 1'b0);
    chk(int'(root_count) == 3, "c1 R8 three roots", int'(root_count), 3);

    // R10 nonzero constant
    for (int k = 0; k <= T_MAX; k++) mem[k] = '0;
    mem[0] = 5'h07;
    run("c2 R10", 0, 1'b0, 1'b0);
    chk(root_count == '0, "c2 R10 none", int'(root_count), 0);

    // R10 zero constant
    mem[0] = '0;
    run("c3 R10", 0, 1'b0, 1'b0);
    chk(int'(root_count) == N, "c3 R10 all", int'(root_count), N);

    // full degree, back-pressure, start poke while busy (R6, R9)
    rt[0] = elem(3); rt[1] = elem(8); rt[2] = elem(12);
    rt[3] = elem(21); rt[4] = elem(30); rt[5] = elem(31);
    build(6, rt, 1);
    run("c4 R6 R9", 6, 1'b1, 1'b1);
    chk(int'(root_count) == 6, "c4 R9 six roots", int'(root_count), 6);

    // repeated root
    rt[0] = elem(5); rt[1] = elem(5); rt[2] = elem(10);
    build(3, rt, 1);
    run("c5", 3, 1'b0, 1'b0);
    chk(int'(root_count) == 2, "c5 R2 distinct", int'(root_count), 2);

    // scaled, non-monic polynomial
    rt[0] = '0; rt[1] = elem(1); rt[2] = elem(4);
    build(3, rt, elem(7));
    run("c6", 3, 1'b1, 1'b0);
    chk(int'(root_count) == 3, "c6 R2 scaled", int'(root_count), 3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule